// File: doc/BRIEF.md
# Four-Channel DMA Priority Arbiter

This block chooses which of four DMA channels owns the bus next. Each channel presents a request line and a 3-bit bandwidth-control code. With every code non-zero the channels rank in ascending number, channel 0 first. A channel whose code is zero moves one place ahead of its lower-numbered neighbour, but only when that neighbour's code is non-zero. The promoted channel never passes any channel beyond that neighbour. The same ranking resolves requests that arrive together, whether they come from software starts or from external request pins.

The result is a registered one-hot grant with a valid flag. Once a channel holds the grant, it keeps it for as long as its request stays asserted. The rank matters only when the current grant is released. Throttling by non-zero codes, the bus protocol and the transfer datapath are handled by other blocks.

Top module: `dma_prio_arbiter`

## Requirements
- R1: With all four codes non-zero, a free grant goes to the lowest-numbered requesting channel.
- R2: Channel i (1 to 3) with code 000, when channel i-1 has a non-zero code, ranks directly ahead of channel i-1 and behind every channel that ranked ahead of i-1 (code 000 on channel 3 alone gives order 0,1,3,2; code 000 on channel 1 alone gives 1,0,2,3).
- R3: When two adjacent channels both have code 000, the upper one is not promoted over the lower one (codes 000 on channels 1 and 2 only give order 1,0,2,3; all codes 000 give ascending order).
- R4: Code 000 on channel 0 alone has no effect on the order.
- R5: The grant is registered. It reflects the requests and codes sampled at a rising clock edge and is visible after that edge.
- R6: While the granted channel's request stays asserted, the grant does not change, even if a higher-ranked channel requests.
- R7: With no request asserted at an edge, grant_valid is low and grant is all zeros after that edge.
- R8: grant is one-hot or zero, grant_valid is high exactly when grant is non-zero, and a granted channel was requesting at the edge that produced the grant.
- R9: While rst is high, grant is zero and grant_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 4 | Request line per channel, bit i is channel i |
| bw_code | input | 12 | Bandwidth-control codes, bits [3i+2:3i] belong to channel i |
| grant | output | 4 | One-hot grant, bit i is channel i |
| grant_valid | output | 1 | High when some channel holds the grant |

## Verification
Every result of this block is due exactly one clock edge after its stimulus. The grant register is the only storage between the request and code inputs and the outputs. The driver applies each stimulus on a falling edge and queues the value expected after the next rising edge. The monitor compares a short delay after every rising edge, so each queued item meets the edge that produced it. The reference model carries its own copy of the previous grant, which lets the hold rule be predicted without looking inside the design.

// File: rtl/dma_prio_pkg.sv
package dma_prio_pkg;

    localparam int NCH    = 4;
    localparam int CODE_W = 3;
    localparam int IDX_W  = $clog2(NCH);

    typedef logic [IDX_W-1:0]  chan_idx_t;
    typedef logic [CODE_W-1:0] bw_code_t;
    typedef chan_idx_t [NCH-1:0] rank_order_t;  // slot 0 is highest rank

    typedef struct packed {
        logic           valid;
        logic [NCH-1:0] vec;
    } grant_t;

    localparam grant_t GRANT_NONE = '{valid: 1'b0, vec: '0};

    function automatic logic [NCH-1:0] idx_to_onehot(input chan_idx_t idx);
        logic [NCH-1:0] v;
        v = '0;
        v[idx] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/dma_prio_order.sv
module dma_prio_order
    import dma_prio_pkg::*;
(
    input  logic [NCH*CODE_W-1:0] codes,
    output rank_order_t           order
);

    logic [NCH-1:0] promote;

    assign promote[0] = 1'b0;  // channel 0 has no lower neighbour

    for (genvar c = 1; c < NCH; c++) begin : g_promote
        bw_code_t self_code;
        bw_code_t below_code;
        assign self_code  = codes[c*CODE_W +: CODE_W];
        assign below_code = codes[(c-1)*CODE_W +: CODE_W];
        assign promote[c] = (self_code == '0) && (below_code != '0);
    end

    // Swaps never overlap: a promoted channel has a zero code, which blocks
    // the channel above it from being promoted in turn.
    always_comb begin
        for (int s = 0; s < NCH; s++) begin
            order[s] = chan_idx_t'(s);
        end
        for (int c = 1; c < NCH; c++) begin
            if (promote[c]) begin
                order[c-1] = chan_idx_t'(c);
                order[c]   = chan_idx_t'(c - 1);
            end
        end
    end

endmodule

// File: rtl/dma_prio_pick.sv
module dma_prio_pick
    import dma_prio_pkg::*;
(
    input  rank_order_t    order,
    input  logic [NCH-1:0] req,
    input  grant_t         cur,
    output grant_t         nxt
);

    logic hold_hit;

    assign hold_hit = cur.valid && ((cur.vec & req) != '0);

    always_comb begin
        nxt = GRANT_NONE;
        if (hold_hit) begin
            nxt = cur;
        end else begin
            // scan from lowest rank upward so the highest-ranked requester wins
            for (int s = NCH - 1; s >= 0; s--) begin
                if (req[order[s]]) begin
                    nxt.valid = 1'b1;
                    nxt.vec   = idx_to_onehot(order[s]);
                end
            end
        end
    end

endmodule

// File: rtl/dma_prio_arbiter.sv
module dma_prio_arbiter
    import dma_prio_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NCH-1:0]        req,
    input  logic [NCH*CODE_W-1:0] bw_code,
    output logic [NCH-1:0]        grant,
    output logic                  grant_valid
);

    rank_order_t order;
    grant_t      grant_q;
    grant_t      grant_d;

    dma_prio_order i_order (
        .codes (bw_code),
        .order (order)
    );

    dma_prio_pick i_pick (
        .order (order),
        .req   (req),
        .cur   (grant_q),
        .nxt   (grant_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            grant_q <= GRANT_NONE;
        end else begin
            grant_q <= grant_d;
        end
    end

    assign grant       = grant_q.vec;
    assign grant_valid = grant_q.valid;

endmodule

// File: rtl/dma_prio_arbiter_chk.sv
module dma_prio_arbiter_chk
    import dma_prio_pkg::*;
(
    input logic           clk,
    input logic           rst,
    input logic [NCH-1:0] req,
    input logic [NCH-1:0] grant,
    input logic           grant_valid
);

    a_r8_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    a_r8_valid_match: assert property (@(posedge clk) disable iff (rst)
        grant_valid == (grant != '0));

    a_r8_granted_was_requesting: assert property (@(posedge clk) disable iff (rst)
        (grant != '0) |-> (($past(req) & grant) != '0));

    a_r7_idle: assert property (@(posedge clk) disable iff (rst)
        (req == '0) |=> !grant_valid);

    a_r6_hold: assert property (@(posedge clk) disable iff (rst)
        (grant_valid && ((grant & req) != '0)) |=> $stable(grant));

    a_r9_reset: assert property (@(posedge clk)
        $past(rst) |-> (!grant_valid && grant == '0));

endmodule

bind dma_prio_arbiter dma_prio_arbiter_chk i_chk (
    .clk         (clk),
    .rst         (rst),
    .req         (req),
    .grant       (grant),
    .grant_valid (grant_valid)
);

// File: tb/test_dma_prio_arbiter.sv
module test_dma_prio_arbiter;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  req = '0;
    logic [11:0] bw_code = '0;
    logic [3:0]  grant;
    logic        grant_valid;

    int n_checks = 0;
    int n_fail   = 0;

    typedef struct {
        logic [3:0] exp_grant;
        string      tag;
    } item_t;

    item_t      sb_q[$];
    logic [3:0] model_prev = '0;

    always #5 clk = ~clk;

    dma_prio_arbiter i_dma_prio_arbiter (
        .clk         (clk),
        .rst         (rst),
        .req         (req),
        .bw_code     (bw_code),
        .grant       (grant),
        .grant_valid (grant_valid)
    );

    function automatic logic [3:0] model(input logic [3:0] r, input logic [11:0] c,
                                         input logic [3:0] prev);
        int rank[4];
        for (int k = 0; k < 4; k++) rank[k] = k;
        for (int k = 1; k < 4; k++) begin
            if (c[3*k +: 3] == 3'b000 && c[3*(k-1) +: 3] != 3'b000) begin
                rank[k]   = k - 1;
                rank[k-1] = k;
            end
        end
        if ((prev & r) != 4'b0) return prev;
        for (int rk = 0; rk < 4; rk++) begin
            for (int k = 0; k < 4; k++) begin
                if (rank[k] == rk && r[k]) return 4'b1 << k;
            end
        end
        return 4'b0;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input logic [3:0] r, input logic [11:0] c, input string tag);
        item_t it;
        @(negedge clk);
        req     = r;
        bw_code = c;
        it.exp_grant = model(r, c, model_prev);
        it.tag       = (r == 4'b0) ? "R7" : tag;
        model_prev   = it.exp_grant;
        sb_q.push_back(it);
    endtask

    // monitor: compares shortly after each rising edge
    always @(posedge clk) begin
        #2;
        if (!rst && sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            check(it.tag, {28'b0, grant}, {28'b0, it.exp_grant});
            check({it.tag, "/R8 valid"}, {31'b0, grant_valid},
                  {31'b0, (it.exp_grant != 4'b0)});
        end
    end

    task automatic sweep(input logic [11:0] c, input string tag);
        for (int r = 0; r < 16; r++) begin
            step(4'b0, c, tag);
            step(4'(r), c, tag);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R9: outputs held at zero in reset
        check("R9 grant", {28'b0, grant}, 32'h0);
        check("R9 valid", {31'b0, grant_valid}, 32'h0);
        @(negedge clk);
        rst = 1'b0;
        model_prev = '0;

        // R5: single request shows up one edge later
        step(4'b0100, 12'o5555, "R5");
        step(4'b0000, 12'o5555, "R5");

        sweep(12'o5555, "R1");             // all non-zero
        sweep(12'o0555, "R2 ch3 promoted"); // ch3 zero: 0,1,3,2
        sweep(12'o5505, "R2 ch1 promoted"); // ch1 zero: 1,0,2,3
        sweep(12'o5005, "R3 ch1+ch2 zero"); // 1,0,2,3
        sweep(12'o0000, "R3 all zero");    // ascending
        sweep(12'o5550, "R4 ch0 zero");    // ascending

        // R6: holding grant against higher-ranked requesters
        step(4'b0000, 12'o5555, "R6");
        step(4'b1000, 12'o5555, "R6");
        step(4'b1001, 12'o5555, "R6");
        step(4'b1111, 12'o5555, "R6");
        step(4'b0111, 12'o5555, "R6 release");
        step(4'b0110, 12'o5555, "R6 release");
        step(4'b0100, 12'o5505, "R6 release");
        step(4'b0000, 12'o5505, "R6");

        @(negedge clk);
        @(negedge clk);
        check("R8 queue drained", 32'(sb_q.size()), 32'h0);
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        #2000000;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule